// File: doc/BRIEF.md
# Recirculating Trie Lookup Engine

This block resolves 32-bit addresses against a multi-level trie held in a table with a single read port. An address is accepted on a valid/ready input stream. Its upper half is used as the first table address, and its lower half is parked in an in-flight queue. Each table response is either a leaf, which is delivered on the output stream, or a pointer to the next level. For a pointer, the next table address is the pointer plus the top byte of the parked remainder. The remainder is then shifted up one byte and parked again.

Every lookup shares one table port. Lookups that are already in flight take precedence over new addresses. The in-flight queue can take a push in the same cycle as a pop even when it is full. Because of that, a finishing lookup and a newly arriving one trade places without an idle cycle between them. Results leave in completion order, which can differ from arrival order.

Top module: `trie_lookup_ring`

## Requirements
- R1: Out of reset, `out_valid` is 0 and `in_ready` is 1. No lookup is in flight and no table response is pending.
- R2: An accepted address reads table word `T(in_addr[31:16])` one cycle later. If that word is a leaf, it is presented on `out_entry` in the cycle after the accepting clock edge.
- R3: A non-leaf word with pointer `P` (bits 15:0) triggers the next read at `P` plus bits [15:8] of the remainder held for that lookup. The remainder is then shifted left by 8. For an address A, the second read is at `P1 + A[15:8]` and the third read is at `P2 + A[7:0]`. A lookup needing k reads presents its leaf k cycles after acceptance.
- R4: Table word encoding: bit 31 is the leaf flag, bits 30:16 are zero, and bits 15:0 are the payload. For table address `a`:
  - If `a[15:14]=2'b11`, the word is a leaf with payload `a`.
  - Otherwise, if `a[0]=1`, the word is a leaf with payload `a`.
  - Otherwise, if `a[15:14]=2'b10`, the word is a pointer `{2'b11, a[7:2], 8'h00}`.
  - Otherwise, the word is a pointer `{2'b10, a[13:8], 8'h00}`.
- R5: In any cycle where the oldest pending response is a pointer, `in_ready` is 0, because the recirculating lookup takes the table port.
- R6: `out_valid` is only ever 1 with a leaf word (bit 31 set). While `out_valid` is 1 and `out_ready` is 0, `out_entry` holds its value into the next cycle.
- R7: At most DEPTH lookups are in flight. When DEPTH are in flight and no leaf leaves in that cycle, `in_ready` is 0.
- R8: With DEPTH lookups in flight, `in_ready` is 1 in any cycle where a leaf is taken (`out_valid` and `out_ready` both 1). A new address can enter in that same cycle.
- R9: Every accepted address produces exactly one output word, equal to the leaf reached through R2 to R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Address offered |
| in_ready | output | 1 | Address accepted at this clock edge if offered |
| in_addr | input | 32 | Address to resolve |
| out_valid | output | 1 | Leaf word available |
| out_ready | input | 1 | Consumer takes the leaf word at this edge |
| out_entry | output | 32 | Leaf table word |

## Verification
A lookup needing k table reads shows its leaf on `out_entry` exactly k cycles after its accepting edge. `in_ready` reacts within the same cycle to a pending pointer response and to `out_ready`. The bench drives its inputs on the falling edge and samples one time step later. It counts rising edges from acceptance, so the directed cases check the leaf latency exactly and confirm `out_valid` stays low in the cycles before it. In the random phase, the order of completion depends on how many reads each lookup needs. There, each accepted address is scored against the multiset of leaves still outstanding, rather than against a fixed cycle.

// File: rtl/tlr_pkg.sv
// Shared widths and the table content model for the trie lookup engine.
// Assumes a 32-bit address split into two 16-bit halves and 8-bit strides.
package tlr_pkg;
    localparam int unsigned ADDR_W   = 32;
    localparam int unsigned HALF_W   = ADDR_W / 2;
    localparam int unsigned STRIDE_W = HALF_W / 2;
    localparam int unsigned ENTRY_W  = 32;
    localparam int unsigned LEAF_BIT = ENTRY_W - 1;
    localparam int unsigned PAD_W    = ENTRY_W - 1 - HALF_W;

    // Computed table word for one address (three-level trie, always terminates).
    function automatic logic [ENTRY_W-1:0] table_entry(input logic [HALF_W-1:0] a);
        logic [HALF_W-1:0] ptr;
        if (a[HALF_W-1:HALF_W-2] == 2'b11 || a[0]) begin
            return {1'b1, {PAD_W{1'b0}}, a};
        end
        if (a[HALF_W-1:HALF_W-2] == 2'b10) begin
            ptr = {2'b11, a[7:2], {STRIDE_W{1'b0}}};
        end else begin
            ptr = {2'b10, a[13:8], {STRIDE_W{1'b0}}};
        end
        return {1'b0, {PAD_W{1'b0}}, ptr};
    endfunction
endpackage

// File: rtl/tlr_fifo.sv
// Circular queue that accepts a push while full provided a pop happens in the
// same cycle. The caller guarantees it never pushes into a full queue without
// popping and never pops an empty queue. The head is read combinationally.
module tlr_fifo #(
    parameter int unsigned W     = 16,
    parameter int unsigned DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic                       pop,
    input  logic [W-1:0]               din,
    output logic [W-1:0]               head,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] rd_ptr;
    logic [PTR_W-1:0] wr_ptr;
    logic [CNT_W-1:0] cnt;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    // Storage write; when full with pop the slot written is the one leaving.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= din;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push) wr_ptr <= step(wr_ptr);
            if (pop)  rd_ptr <= step(rd_ptr);
            case ({push, pop})
                2'b10:   cnt <= cnt + CNT_W'(1);
                2'b01:   cnt <= cnt - CNT_W'(1);
                default: cnt <= cnt;
            endcase
        end
    end

    assign head  = mem[rd_ptr];
    assign count = cnt;
endmodule

// File: rtl/tlr_ram.sv
// Table model: a read issued in one cycle delivers its word in the next.
// Words wait in an in-order response queue until consumed. The queue depth
// matches the number of lookups allowed in flight, so it cannot overflow.
module tlr_ram #(
    parameter int unsigned DEPTH = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           req_v,
    input  logic [tlr_pkg::HALF_W-1:0]     req_addr,
    input  logic                           resp_pop,
    output logic                           resp_v,
    output logic [tlr_pkg::ENTRY_W-1:0]    resp_data,
    output logic [$clog2(DEPTH+1)-1:0]     resp_cnt
);
    logic [tlr_pkg::ENTRY_W-1:0] rd_word;

    // Table lookup for the address presented this cycle.
    always_comb rd_word = tlr_pkg::table_entry(req_addr);

    tlr_fifo #(.W(tlr_pkg::ENTRY_W), .DEPTH(DEPTH)) u_resp_q (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (req_v),
        .pop   (resp_pop),
        .din   (rd_word),
        .head  (resp_data),
        .count (resp_cnt)
    );

    assign resp_v = (resp_cnt != '0);
endmodule

// File: rtl/tlr_arbiter.sv
// Chooses what the shared table port does this cycle. A pointer response
// recirculates unconditionally. A leaf leaves when the consumer is ready.
// A new address enters only when no recirculation claims the port and the
// in-flight queue has room, counting a slot freed by a leaf leaving now.
module tlr_arbiter (
    input  logic in_valid,
    input  logic out_ready,
    input  logic fifo_full,
    input  logic resp_v,
    input  logic resp_leaf,
    output logic in_ready,
    output logic out_valid,
    output logic enter_fire,
    output logic exit_fire,
    output logic recirc_fire
);
    // Decide the three mutually exclusive-by-port actions.
    always_comb begin
        recirc_fire = resp_v && !resp_leaf;
        out_valid   = resp_v && resp_leaf;
        exit_fire   = out_valid && out_ready;
        in_ready    = !recirc_fire && (!fifo_full || exit_fire);
        enter_fire  = in_valid && in_ready;
    end
endmodule

// File: rtl/trie_lookup_ring.sv
// Top level of the recirculating trie lookup engine. Combines the arbiter,
// the in-flight remainder queue and the table model. Results leave in
// completion order. Assumes DEPTH >= 1.
module trie_lookup_ring #(
    parameter int unsigned DEPTH = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [31:0] in_addr,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [31:0] out_entry
);
    import tlr_pkg::*;

    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    logic                fifo_push;
    logic                fifo_pop;
    logic [HALF_W-1:0]   fifo_din;
    logic [HALF_W-1:0]   fifo_head;
    logic [CNT_W-1:0]    fifo_cnt;
    logic                fifo_full;
    logic                req_v;
    logic [HALF_W-1:0]   req_addr;
    logic                resp_v;
    logic                resp_leaf;
    logic [ENTRY_W-1:0]  resp_data;
    logic [CNT_W-1:0]    resp_cnt;
    logic                enter_fire;
    logic                exit_fire;
    logic                recirc_fire;

    assign fifo_full = (fifo_cnt == CNT_W'(DEPTH));
    assign resp_leaf = resp_data[LEAF_BIT];

    tlr_arbiter u_arb (
        .in_valid    (in_valid),
        .out_ready   (out_ready),
        .fifo_full   (fifo_full),
        .resp_v      (resp_v),
        .resp_leaf   (resp_leaf),
        .in_ready    (in_ready),
        .out_valid   (out_valid),
        .enter_fire  (enter_fire),
        .exit_fire   (exit_fire),
        .recirc_fire (recirc_fire)
    );

    // Steer the table port and the queue input between entry and recirculation.
    always_comb begin
        fifo_pop  = exit_fire || recirc_fire;
        fifo_push = enter_fire || recirc_fire;
        req_v     = enter_fire || recirc_fire;
        if (recirc_fire) begin
            req_addr = resp_data[HALF_W-1:0]
                     + HALF_W'(fifo_head[HALF_W-1 -: STRIDE_W]);
            fifo_din = {fifo_head[STRIDE_W-1:0], {STRIDE_W{1'b0}}};
        end else begin
            req_addr = in_addr[ADDR_W-1:HALF_W];
            fifo_din = in_addr[HALF_W-1:0];
        end
    end

    tlr_fifo #(.W(HALF_W), .DEPTH(DEPTH)) u_inflight (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (fifo_push),
        .pop   (fifo_pop),
        .din   (fifo_din),
        .head  (fifo_head),
        .count (fifo_cnt)
    );

    tlr_ram #(.DEPTH(DEPTH)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_v     (req_v),
        .req_addr  (req_addr),
        .resp_pop  (fifo_pop),
        .resp_v    (resp_v),
        .resp_data (resp_data),
        .resp_cnt  (resp_cnt)
    );

    assign out_entry = resp_data;
endmodule

// File: rtl/tlr_checker.sv
// Protocol and structural properties of trie_lookup_ring. Attached by bind.
module tlr_checker #(
    parameter int unsigned DEPTH = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       in_ready,
    input logic                       out_valid,
    input logic                       out_ready,
    input logic [31:0]                out_entry,
    input logic                       resp_v,
    input logic                       resp_leaf,
    input logic [$clog2(DEPTH+1)-1:0] fifo_cnt,
    input logic [$clog2(DEPTH+1)-1:0] resp_cnt
);
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    // R3: every parked remainder is paired with exactly one table response or read.
    p_pairing_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_cnt == resp_cnt);

    // R5: a pointer response blocks new entry.
    p_recirc_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_v && !resp_leaf) |-> !in_ready);

    // R6: only leaf words are offered.
    p_leaf_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_entry[31]);

    // R6: an unaccepted result is held.
    p_out_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_entry)));

    // R7: occupancy bound.
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_cnt <= CNT_W'(DEPTH));

    // R7: full with nothing leaving refuses entry.
    p_full_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_cnt == CNT_W'(DEPTH) && !(out_valid && out_ready)) |-> !in_ready);

    // R8: a leaving leaf frees its slot in the same cycle.
    p_no_dead_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_cnt == CNT_W'(DEPTH) && out_valid && out_ready) |-> in_ready);
endmodule

bind trie_lookup_ring tlr_checker #(.DEPTH(DEPTH)) u_tlr_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_entry (out_entry),
    .resp_v    (resp_v),
    .resp_leaf (resp_leaf),
    .fifo_cnt  (fifo_cnt),
    .resp_cnt  (resp_cnt)
);

// File: tb/tb_trie_lookup_ring.sv
// Directed latency, hold and full-queue cases, then seeded random traffic
// scored against a multiset of expected leaves.
module tb_trie_lookup_ring;
    localparam int DEPTH  = 4;
    localparam int N_RAND = 400;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_addr = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_entry;

    int checks = 0;
    int errors = 0;

    logic [31:0] exp_val  [1024];
    bit          exp_live [1024];
    int          n_exp = 0;

    always #2 clk = ~clk;

    trie_lookup_ring #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_addr(in_addr), .out_valid(out_valid), .out_ready(out_ready),
        .out_entry(out_entry)
    );

    // Table word per R4.
    function automatic logic [31:0] tbl(input logic [15:0] a);
        if (a[15:14] == 2'b11 || a[0]) return {16'h8000, a};
        if (a[15:14] == 2'b10) return {16'h0000, 2'b11, a[7:2], 8'h00};
        return {16'h0000, 2'b10, a[13:8], 8'h00};
    endfunction

    // Number of table reads a lookup needs (R2, R3).
    function automatic int reads(input logic [31:0] ip);
        logic [31:0] e;
        e = tbl(ip[31:16]);
        if (e[31]) return 1;
        e = tbl(e[15:0] + {8'h00, ip[15:8]});
        if (e[31]) return 2;
        return 3;
    endfunction

    // Leaf reached by a lookup (R2, R3).
    function automatic logic [31:0] leaf_of(input logic [31:0] ip);
        logic [31:0] e;
        e = tbl(ip[31:16]);
        if (e[31]) return e;
        e = tbl(e[15:0] + {8'h00, ip[15:8]});
        if (e[31]) return e;
        return tbl(e[15:0] + {8'h00, ip[7:0]});
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // One isolated lookup with exact latency, hold and consume checks.
    task automatic run_one(input logic [31:0] ip);
        int k;
        logic [31:0] want;
        k = reads(ip);
        want = leaf_of(ip);
        @(negedge clk);
        in_valid = 1'b1;
        in_addr  = ip;
        #1 check(in_ready == 1'b1, "R2 idle in_ready", {31'd0, in_ready}, 32'd1);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        for (int i = 1; i <= k; i++) begin
            #1;
            if (i < k) begin
                check(out_valid == 1'b0, "R3 early out_valid", {31'd0, out_valid}, 32'd0);
                if (i == 1)
                    check(in_ready == 1'b0, "R5 recirc blocks entry", {31'd0, in_ready}, 32'd0);
            end else begin
                check(out_valid == 1'b1, (k == 1) ? "R2 latency" : "R3 latency",
                      {31'd0, out_valid}, 32'd1);
                check(out_entry == want, (k == 1) ? "R2 data" : "R3 data", out_entry, want);
            end
            if (i < k) @(negedge clk);
        end
        @(negedge clk);
        #1 check(out_valid && out_entry == want, "R6 hold", out_entry, want);
        out_ready = 1'b1;
        @(negedge clk);
        #1 check(out_valid == 1'b0, "R6 consumed", {31'd0, out_valid}, 32'd0);
        out_ready = 1'b0;
    endtask

    // Score one leaving word against outstanding expectations (R9).
    task automatic score(input logic [31:0] got);
        bit found = 1'b0;
        for (int j = 0; j < n_exp; j++) begin
            if (!found && exp_live[j] && exp_val[j] == got) begin
                exp_live[j] = 1'b0;
                found = 1'b1;
            end
        end
        check(found, "R9 unexpected leaf", got, 32'hFFFFFFFF);
        check(got[31], "R6 leaf flag", got, got | 32'h80000000);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(out_valid == 1'b0, "R1 out_valid", {31'd0, out_valid}, 32'd0);
        check(in_ready == 1'b1, "R1 in_ready", {31'd0, in_ready}, 32'd1);

        // Directed: one, two and three read lookups (R2, R3, R4, R5, R6).
        run_one(32'h0001_ABCD);
        run_one(32'h0002_3500);
        run_one(32'h0002_3400);
        run_one(32'hC123_4567);
        run_one(32'h8000_1200);

        // Fill with leaf lookups while the consumer stalls (R7, R8).
        for (int i = 0; i < DEPTH; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_addr  = {16'(2 * i + 1), 16'h0000};
            @(posedge clk);
        end
        @(negedge clk);
        in_addr = 32'h0009_0000;
        #1 check(in_ready == 1'b0, "R7 full refuses", {31'd0, in_ready}, 32'd0);
        @(negedge clk);
        out_ready = 1'b1;
        #1 check(in_ready == 1'b1, "R8 same-cycle swap", {31'd0, in_ready}, 32'd1);
        check(out_entry == tbl(16'h0001), "R8 first out", out_entry, tbl(16'h0001));
        @(negedge clk);
        in_valid = 1'b0;
        for (int i = 1; i <= DEPTH; i++) begin
            #1;
            check(out_valid && out_entry == tbl(16'(2 * i + 1)), "R8 drain order",
                  out_entry, tbl(16'(2 * i + 1)));
            @(negedge clk);
        end
        #1 check(out_valid == 1'b0, "R8 drained", {31'd0, out_valid}, 32'd0);

        // Random traffic (R9).
        begin
            int sent = 0;
            int got = 0;
            int guard = 0;
            bit held = 1'b0;
            while ((sent < N_RAND || got < sent) && guard < 20000) begin
                @(negedge clk);
                guard++;
                out_ready = ($urandom % 4) != 0;
                if (!held && sent < N_RAND && ($urandom % 2) == 0) begin
                    held = 1'b1;
                    in_addr = $urandom;
                end
                in_valid = held;
                #1;
                if (in_valid && in_ready) begin
                    exp_val[n_exp]  = leaf_of(in_addr);
                    exp_live[n_exp] = 1'b1;
                    n_exp++;
                    sent++;
                    held = 1'b0;
                end
                if (out_valid && out_ready) begin
                    score(out_entry);
                    got++;
                end
            end
            @(negedge clk);
            in_valid = 1'b0;
            check(got == N_RAND, "R9 output count", 32'(got), 32'(N_RAND));
        end
        summary();
    end
endmodule